// File: doc/BRIEF.md
# Monitor Host Register Interrupt Bank

This block is the host-facing register bank of a monitoring converter. A host issues word-indexed reads and writes over a simple request bus. The bank stores a configuration word and a channel-control word, keeps a sticky interrupt status register with its mask, and drives one level-sensitive interrupt line. It also builds a live status word from the occupancy of the converter's read-data FIFO.

The FIFO storage and command execution live outside the block. A read of the read-data offset returns the FIFO head and pulses a pop strobe. A write to the command offset pulses a push strobe and forwards the written word. Alarm and over-temperature events arrive as plain level inputs and are folded into the status register every cycle.

Request and response rules:
- Every request is accepted in the cycle it is presented; there is no back-pressure.
- A read returns its response (`rsp_valid` with `rsp_data`) exactly one cycle later. The requester must be able to take it.
- Writes produce no response.

Top module: `mon_regbank`

## Requirements
- R1: Word offsets are 0 config, 1 interrupt status, 2 interrupt mask, 3 FIFO status, 4 command, 5 read data, 6 channel control. Every read raises `rsp_valid` for one cycle, one clock after the request, carrying the value the register held in the request cycle.
- R2: Offsets 3 and 5 are read-only. Offset 4 is write-only. Any offset of 7 or above, and any access in the wrong direction, changes no state and raises neither strobe. Such a read returns zero.
- R3: Interrupt status bits stay set until written with a one at offset 1. If an event sets a bit in the same cycle that a write clears it, the bit stays set.
- R4: Each cycle, `alarm_i[6:0]` is ORed into status bits [6:0] and `ot_i` into status bit 7.
- R5: Status bit 8 is set whenever the FIFO level is strictly greater than config bits [19:16]. Status bit 9 is set in every cycle and cannot stay cleared.
- R6: `irq_o` is high exactly when some status bit is one while its mask bit is zero.
- R7: The mask resets to 0xFFFFFFFF. A write stores only bits [9:0] and forces the upper bits to zero.
- R8: Offset 3 reads the FIFO level in bits [15:12] and always sets bit 10. Bit 8 is set when the level is zero, and bit 9 is set when the level equals DEPTH. All other bits read zero.
- R9: After reset, config reads 0x00001014, channel control reads 0x00000010 and interrupt status reads 0x200.
- R10: A config write stores the full word. A channel-control write stores the data ANDed with 0x00FFFEFF.
- R11: A read of offset 5 pulses `pop_o` in the request cycle. The response carries `dfifo_head_i`, zero-extended.
- R12: A write of offset 4 pulses `cmd_push_o` in the request cycle, with `cmd_data_o` equal to the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 32 | Read response data |
| dfifo_level_i | input | LVL_W | Read-data FIFO entry count |
| dfifo_head_i | input | HEAD_W | Read-data FIFO head entry |
| alarm_i | input | 7 | Alarm event levels |
| ot_i | input | 1 | Over-temperature event level |
| pop_o | output | 1 | Pop strobe toward the read-data FIFO |
| cmd_push_o | output | 1 | Push strobe toward the command channel |
| cmd_data_o | output | 32 | Command word pushed |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: ADDR_W of 4 and DEPTH of 15. The 4-bit address reaches the unmapped offsets 7 to 15, so the zero-return and no-effect rules can be exercised. A depth of 15 fills the 4-bit level field, so the full flag and the top of the threshold range become reachable. With these values, the threshold comparison can be probed on both sides of equality, and the set-versus-clear collision can be forced in a single cycle.

// File: rtl/mon_regbank_pkg.sv
package mon_regbank_pkg;
  localparam int NREG    = 7;
  localparam int DATA_W  = 32;
  localparam int INT_W   = 10;
  localparam int ALM_W   = 7;

  localparam int OFF_CFG   = 0;
  localparam int OFF_ISTS  = 1;
  localparam int OFF_IMSK  = 2;
  localparam int OFF_MSTAT = 3;
  localparam int OFF_CMD   = 4;
  localparam int OFF_RDAT  = 5;
  localparam int OFF_CTL   = 6;

  // direction legality per offset, bit i = offset i
  localparam logic [NREG-1:0] RD_OK = 7'b1101111;
  localparam logic [NREG-1:0] WR_OK = 7'b1010111;

  localparam logic [DATA_W-1:0] CFG_RST   = 32'h0000_1014;
  localparam logic [DATA_W-1:0] CTL_RST   = 32'h0000_0010;
  localparam logic [DATA_W-1:0] CTL_WMASK = 32'h00FF_FEFF;
  localparam logic [INT_W-1:0]  STS_RST   = 10'h200;

  localparam int THR_LSB = 16;
  localparam int FIELD_W = 4;

  localparam int BIT_CMD_LOW = 9;
  localparam int BIT_DGT     = 8;
  localparam int BIT_OT      = 7;

  localparam int LVL_LSB    = 12;
  localparam int BIT_CEMPTY = 10;
  localparam int BIT_DFULL  = 9;
  localparam int BIT_DEMPTY = 8;
endpackage

// File: rtl/mrb_decode.sv
module mrb_decode
  import mon_regbank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [NREG-1:0]   rd_hit,
  output logic [NREG-1:0]   wr_hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_off
    logic sel;
    assign sel       = (req_addr == ADDR_W'(i));
    assign rd_hit[i] = req_valid & ~req_write & sel & RD_OK[i];
    assign wr_hit[i] = req_valid &  req_write & sel & WR_OK[i];
  end
endmodule

// File: rtl/mrb_irq.sv
module mrb_irq
  import mon_regbank_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_en,
  input  logic [INT_W-1:0]   clr_bits,
  input  logic               mask_we,
  input  logic [DATA_W-1:0]  mask_wdata,
  input  logic [ALM_W-1:0]   alarm_i,
  input  logic               ot_i,
  input  logic [LVL_W-1:0]   level,
  input  logic [FIELD_W-1:0] thr,
  output logic [INT_W-1:0]   sts_o,
  output logic [DATA_W-1:0]  mask_o,
  output logic               irq_o
);
  localparam logic [DATA_W-1:0] MASK_KEEP = DATA_W'((1 << INT_W) - 1);

  logic [INT_W-1:0]  sts_q;
  logic [DATA_W-1:0] mask_q;
  logic [INT_W-1:0]  set_vec;
  logic [INT_W-1:0]  clr_vec;
  logic              above;

  assign above   = 32'(level) > 32'(thr);
  assign set_vec = {1'b1, above, ot_i, alarm_i};
  assign clr_vec = clr_en ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= STS_RST;
      mask_q <= '1;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (mask_we) mask_q <= mask_wdata & MASK_KEEP;
    end
  end

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
  assign irq_o  = |(sts_q & ~mask_q[INT_W-1:0]);
endmodule

// File: rtl/mrb_status.sv
module mrb_status
  import mon_regbank_pkg::*;
#(
  parameter int DEPTH = 15,
  parameter int LVL_W = 4
) (
  input  logic [LVL_W-1:0]  level,
  output logic [DATA_W-1:0] word
);
  always_comb begin
    word = '0;
    word[LVL_LSB +: FIELD_W] = FIELD_W'(level);
    word[BIT_CEMPTY]         = 1'b1;
    word[BIT_DEMPTY]         = (level == '0);
    word[BIT_DFULL]          = (level == LVL_W'(DEPTH));
  end
endmodule

// File: rtl/mon_regbank.sv
module mon_regbank
  import mon_regbank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEPTH  = 15,
  parameter int HEAD_W = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  input  logic [LVL_W-1:0]  dfifo_level_i,
  input  logic [HEAD_W-1:0] dfifo_head_i,
  input  logic [6:0]        alarm_i,
  input  logic              ot_i,
  output logic              pop_o,
  output logic              cmd_push_o,
  output logic [31:0]       cmd_data_o,
  output logic              irq_o
);
  logic [NREG-1:0]   rd_hit, wr_hit;
  logic [DATA_W-1:0] cfg_q, ctl_q, mask_w, mstat_w, rd_mux;
  logic [INT_W-1:0]  sts_w;
  logic [DATA_W-1:0] words [NREG];

  mrb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  mrb_irq #(.LVL_W(LVL_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .clr_en(wr_hit[OFF_ISTS]), .clr_bits(req_wdata[INT_W-1:0]),
    .mask_we(wr_hit[OFF_IMSK]), .mask_wdata(req_wdata),
    .alarm_i(alarm_i), .ot_i(ot_i),
    .level(dfifo_level_i), .thr(cfg_q[THR_LSB +: FIELD_W]),
    .sts_o(sts_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  mrb_status #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stat (
    .level(dfifo_level_i), .word(mstat_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      ctl_q <= CTL_RST;
    end else begin
      if (wr_hit[OFF_CFG]) cfg_q <= req_wdata;
      if (wr_hit[OFF_CTL]) ctl_q <= req_wdata & CTL_WMASK;
    end
  end

  assign words[OFF_CFG]   = cfg_q;
  assign words[OFF_ISTS]  = DATA_W'(sts_w);
  assign words[OFF_IMSK]  = mask_w;
  assign words[OFF_MSTAT] = mstat_w;
  assign words[OFF_CMD]   = '0;
  assign words[OFF_RDAT]  = DATA_W'(dfifo_head_i);
  assign words[OFF_CTL]   = ctl_q;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_hit[i]) rd_mux = rd_mux | words[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid & ~req_write;
      rsp_data  <= rd_mux;
    end
  end

  assign pop_o      = rd_hit[OFF_RDAT];
  assign cmd_push_o = wr_hit[OFF_CMD];
  assign cmd_data_o = req_wdata;
endmodule

// File: rtl/mrb_checker.sv
module mrb_checker #(
  parameter int ADDR_W = 4,
  parameter int LVL_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic [LVL_W-1:0]  dfifo_level_i,
  input logic [6:0]        alarm_i,
  input logic              ot_i,
  input logic              pop_o,
  input logic              cmd_push_o,
  input logic [31:0]       cmd_data_o,
  input logic              irq_o,
  input logic [9:0]        sts,
  input logic [31:0]       mask,
  input logic [3:0]        thr
);
  logic clr_wr, unmapped_rd, mask_wr;
  assign clr_wr      = req_valid && req_write && (req_addr == ADDR_W'(1));
  assign mask_wr     = req_valid && req_write && (req_addr == ADDR_W'(2));
  assign unmapped_rd = req_valid && !req_write && (32'(req_addr) >= 7);

  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    unmapped_rd |=> (rsp_data == 32'h0)); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr_wr) |-> ((sts & $past(sts)) == $past(sts))); // R3
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ({ot_i, alarm_i} != 8'h0) |=> ((sts[7:0] & $past({ot_i, alarm_i})) == $past({ot_i, alarm_i}))); // R4
  AST_ABOVE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(dfifo_level_i) > 32'(thr)) |=> sts[8]); // R5
  AST_CMD_LOW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sts[9]); // R5
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask[9:0] == 10'h3FF) |-> !irq_o); // R6
  AST_MASK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask[31:10] == 22'h0)); // R7
  AST_POP_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |-> (req_valid && !req_write && req_addr == ADDR_W'(5))); // R11
  AST_PUSH_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_push_o |-> (req_valid && req_write && req_addr == ADDR_W'(4) && cmd_data_o == req_wdata)); // R12
endmodule

bind mon_regbank mrb_checker #(.ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .rsp_data(rsp_data), .dfifo_level_i(dfifo_level_i), .alarm_i(alarm_i),
  .ot_i(ot_i), .pop_o(pop_o), .cmd_push_o(cmd_push_o), .cmd_data_o(cmd_data_o),
  .irq_o(irq_o), .sts(sts_w), .mask(mask_w), .thr(cfg_q[19:16])
);

// File: tb/mon_regbank_test.sv
`timescale 1ns/1ps
module mon_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0]  level = '0;
  logic [15:0] head = '0;
  logic [6:0]  alarm = '0;
  logic        ot = 1'b0;
  logic        pop_o, cmd_push_o, irq_o;
  logic [31:0] cmd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] q_exp [$];
  string       q_tag [$];

  always #2.5 clk = ~clk;

  mon_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .dfifo_level_i(level), .dfifo_head_i(head),
    .alarm_i(alarm), .ot_i(ot), .pop_o(pop_o), .cmd_push_o(cmd_push_o),
    .cmd_data_o(cmd_data_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: issues a read and queues its expected response
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    #1;
    chk({tag, " pop strobe"}, 32'(pop_o), 32'(a == 4'd5));
    chk({tag, " no push on read"}, 32'(cmd_push_o), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    #1;
    chk({tag, " push strobe"}, 32'(cmd_push_o), 32'(a == 4'd4));
    chk({tag, " no pop on write"}, 32'(pop_o), 32'd0);
    if (a == 4'd4) chk({tag, " cmd data"}, cmd_data_o, d);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares each response against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q_exp.size() == 0) begin
        chk("R1 unexpected response", 32'd1, 32'd0);
      end else begin
        chk(q_tag.pop_front(), rsp_data, q_exp.pop_front());
      end
    end
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 irq low with all masked", 32'(irq_o), 32'd0);
    rd(4'd0, 32'h0000_1014, "R9 config reset");
    rd(4'd6, 32'h0000_0010, "R9 channel control reset");
    rd(4'd2, 32'hFFFF_FFFF, "R7 mask reset");
    rd(4'd1, 32'h0000_0200, "R9 status reset");
    rd(4'd3, 32'h0000_0500, "R8 level zero");
    level = 4'd15;
    rd(4'd3, 32'h0000_F600, "R8 level full");
    level = 4'd5;
    rd(4'd3, 32'h0000_5400, "R8 level mid");
    wr(4'd0, 32'h000A_0000, "R10 config write");
    rd(4'd0, 32'h000A_0000, "R10 config readback");
    level = 4'd10;
    wr(4'd1, 32'h0000_03FF, "R3 clear all");
    rd(4'd1, 32'h0000_0200, "R5 level equal threshold");
    level = 4'd11;
    rd(4'd1, 32'h0000_0300, "R5 level above threshold");
    wr(4'd1, 32'h0000_0200, "R5 clear cmd bit");
    rd(4'd1, 32'h0000_0300, "R5 cmd bit persists");
    level = 4'd0;
    wr(4'd1, 32'h0000_03FF, "R3 clear all again");
    rd(4'd1, 32'h0000_0200, "R3 cleared");
    wr(4'd2, 32'hFFFF_FDFF, "R7 mask write");
    rd(4'd2, 32'h0000_01FF, "R7 mask kept bits");
    chk("R6 irq high unmasked bit9", 32'(irq_o), 32'd1);
    wr(4'd2, 32'hFFFF_FFFF, "R7 mask all");
    chk("R6 irq low remasked", 32'(irq_o), 32'd0);
    @(negedge clk); alarm = 7'h05; ot = 1'b1;
    @(negedge clk); alarm = 7'h00; ot = 1'b0;
    rd(4'd1, 32'h0000_0285, "R4 events latched");
    wr(4'd1, 32'h0000_0004, "R3 clear one");
    rd(4'd1, 32'h0000_0281, "R3 single clear");
    @(negedge clk);
    alarm = 7'h01;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd1; req_wdata = 32'h81;
    @(negedge clk);
    alarm = 7'h00; req_valid = 1'b0;
    rd(4'd1, 32'h0000_0201, "R3 set wins over clear");
    wr(4'd1, 32'h0000_0001, "R3 clear bit0");
    rd(4'd1, 32'h0000_0200, "R3 bit0 cleared");
    wr(4'd6, 32'hFFFF_FFFF, "R10 ctl write");
    rd(4'd6, 32'h00FF_FEFF, "R10 ctl masked");
    wr(4'd3, 32'h1234_5678, "R2 write read-only");
    rd(4'd3, 32'h0000_0500, "R2 status unchanged");
    rd(4'd7, 32'h0, "R2 unmapped read 7");
    rd(4'd4, 32'h0, "R2 write-only read");
    head = 16'hBEEF;
    wr(4'd5, 32'h0000_ABCD, "R2 write to read data");
    wr(4'd9, 32'hFFFF_FFFF, "R2 unmapped write");
    rd(4'd0, 32'h000A_0000, "R2 config untouched");
    rd(4'd15, 32'h0, "R2 unmapped read 15");
    rd(4'd5, 32'h0000_BEEF, "R11 pop head");
    wr(4'd4, 32'h0400_1234, "R12 command push");
    repeat (3) @(negedge clk);
    chk("R1 all responses seen", 32'(q_exp.size()), 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule